// File: doc/BRIEF.md
# Sampling Phase Tuning Engine

This block finds a receive sampling phase for a high-speed card interface without software stepping through the codes. After a start pulse it walks a 7-bit delay-line code from 0 to 124 in steps of 4. For each code it loads the code into the delay line with the force control set, runs a calibrate handshake, and then requests one tuning-block transfer from an external command engine. The command engine answers with pass or fail. The engine keeps the longest run of consecutive passing codes. It then loads a final code placed three quarters of the way into that run, resets the data and command lines of the transfer logic, and reports done, with or without error.

Modes that run slowly enough to need no tuning complete at once, with no sweep. If nothing passes, or if the tuned sampling clock is not selected when the sweep ends, the engine undoes its delay-line settings and deselects the tuned clock. It still resets the data and command lines before it reports the error.

Top module: `phase_tune_engine`

## Requirements
- R1: The mode input is encoded as 00 low-speed, 01 SDR50, 10 SDR104 and 11 HS200. A start in low-speed mode, or in SDR50 with the capability bit clear, gives `done_o` high in the cycle after start with `err_o` low. No calibrate, no transfer request and no line reset occur.
- R2: A start in SDR50 with `sdr50_tune_cap_i` set runs the full sweep, as HS200 and SDR104 do.
- R3: A sweep issues exactly 32 one-cycle transfer requests. The code presented with the n-th request is 4·n, for n from 0 to 31.
- R4: Whenever calibrate is high, force-value is also high, and the code stays steady for as long as calibrate is held.
- R5: Calibrate stays high until `dl_calib_ack_i` is seen, or for at most 1000 cycles when no acknowledge arrives. It then falls and the sequence continues.
- R6: Software-tuning mode (`dl_swtune_o`) is high during every transfer request of a sweep.
- R7: The first pass, or a pass that follows a fail, opens a run at the current code with length 1. A pass after a pass lengthens the run by one. A run replaces the best run only if it is strictly longer, so the earliest of equally long runs wins.
- R8: On success the engine loads the code best_start + 4·floor(3·best_len/4) with force and calibrate, as the 33rd calibrate. That code stays on `dl_code_o` with force high after done.
- R9: If no trial passes, done comes with `err_o` high, force and software-tuning are low afterwards, and `clk_sel_clr_o` pulses.
- R10: If `sclk_sel_i` is low when the sweep ends, the engine takes the same error path as R9, even when trials passed.
- R11: Every tuned run ends with a one-cycle `dat_rst_o`, then a one-cycle `cmd_rst_o` in the next cycle, then `done_o` in the cycle after that.
- R12: `busy_o` is high from the cycle after an accepted start through the done cycle, and low after it. A start while busy has no effect on the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a tuning run (accepted when idle) |
| mode_i | input | 2 | Bus speed mode: 00 low, 01 SDR50, 10 SDR104, 11 HS200 |
| sdr50_tune_cap_i | input | 1 | SDR50 needs tuning |
| sclk_sel_i | input | 1 | Tuned sampling clock is selected |
| dl_code_o | output | CODE_W | Delay-line code |
| dl_force_o | output | 1 | Force the code into the delay line |
| dl_calib_o | output | 1 | Calibrate request |
| dl_calib_ack_i | input | 1 | Calibrate bit reads back set |
| dl_swtune_o | output | 1 | Software-tuning mode enable |
| clk_sel_clr_o | output | 1 | One-cycle pulse that deselects the tuned sampling clock |
| tun_req_o | output | 1 | One-cycle tuning-block transfer request |
| tun_rsp_valid_i | input | 1 | One-cycle transfer response valid |
| tun_rsp_pass_i | input | 1 | Transfer passed (with valid) |
| dat_rst_o | output | 1 | Data-line reset pulse |
| cmd_rst_o | output | 1 | Command-line reset pulse |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle completion |
| err_o | output | 1 | Error, valid with done |

## Verification
The assertions check every cycle that calibrate never runs without force and that the code holds while calibrate is high. They also check that requests are single-cycle, land on the 4-step grid and only come with software-tuning on, that the data reset, command reset and done follow one another, and that busy holds until done. Only the bench scenarios show the parts that depend on the response pattern. These are the run bookkeeping with its earliest-wins tie rule, the three-quarter placement, the two error paths, the skip decision for each mode and the 1000-cycle calibrate timeout.

// File: rtl/tune_pkg.sv
package tune_pkg;
   typedef enum logic [1:0] {
      MD_LOW    = 2'b00,
      MD_SDR50  = 2'b01,
      MD_SDR104 = 2'b10,
      MD_HS200  = 2'b11
   } bus_mode_e;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_LOAD,
      ST_CAL,
      ST_REQ,
      ST_WAIT,
      ST_EVAL,
      ST_RDAT,
      ST_RCMD,
      ST_DONE
   } tune_state_e;
endpackage

// File: rtl/tune_cal_poll.sv
module tune_cal_poll #(
   parameter int POLL_LIMIT = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active_i,
   input  logic ack_i,
   output logic finish_o
);
   localparam int CNT_W = $clog2(POLL_LIMIT);

   logic [CNT_W-1:0] cnt_q;
   logic             at_limit;

   assign at_limit = (cnt_q == CNT_W'(POLL_LIMIT - 1));
   assign finish_o = active_i && (ack_i || at_limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!active_i || finish_o) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/tune_run_track.sv
module tune_run_track #(
   parameter int CODE_W = 7,
   parameter int LEN_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              upd_i,
   input  logic              pass_i,
   input  logic [CODE_W-1:0] code_i,
   output logic [CODE_W-1:0] best_start_o,
   output logic [LEN_W-1:0]  best_len_o
);
   logic              prev_q;
   logic [LEN_W-1:0]  run_len_q, nxt_len;
   logic [CODE_W-1:0] run_start_q, nxt_start;

   always_comb begin
      nxt_len   = run_len_q;
      nxt_start = run_start_q;
      if (pass_i) begin
         if (prev_q) begin
            nxt_len = run_len_q + 1'b1;
         end else begin
            nxt_len   = LEN_W'(1);
            nxt_start = code_i;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q       <= 1'b0;
         run_len_q    <= '0;
         run_start_q  <= '0;
         best_len_o   <= '0;
         best_start_o <= '0;
      end else if (clr_i) begin
         prev_q       <= 1'b0;
         run_len_q    <= '0;
         run_start_q  <= '0;
         best_len_o   <= '0;
         best_start_o <= '0;
      end else if (upd_i) begin
         prev_q      <= pass_i;
         run_len_q   <= nxt_len;
         run_start_q <= nxt_start;
         if (nxt_len > best_len_o) begin
            best_len_o   <= nxt_len;
            best_start_o <= nxt_start;
         end
      end
   end
endmodule

// File: rtl/tune_place.sv
module tune_place #(
   parameter int CODE_W    = 7,
   parameter int LEN_W     = 6,
   parameter int CODE_STEP = 4
) (
   input  logic [CODE_W-1:0] best_start_i,
   input  logic [LEN_W-1:0]  best_len_i,
   output logic [CODE_W-1:0] final_code_o
);
   logic [LEN_W+1:0] three_len;
   logic [LEN_W+1:0] quarter;
   int               offset;

   always_comb begin
      three_len    = {2'b00, best_len_i} + {1'b0, best_len_i, 1'b0};
      quarter      = three_len >> 2;
      offset       = int'(quarter) * CODE_STEP;
      final_code_o = best_start_i + CODE_W'(offset);
   end
endmodule

// File: rtl/phase_tune_engine.sv
module phase_tune_engine
   import tune_pkg::*;
#(
   parameter int CODE_W     = 7,
   parameter int CODE_STEP  = 4,
   parameter int CODE_LAST  = 124,
   parameter int POLL_LIMIT = 1000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [1:0]        mode_i,
   input  logic              sdr50_tune_cap_i,
   input  logic              sclk_sel_i,
   output logic [CODE_W-1:0] dl_code_o,
   output logic              dl_force_o,
   output logic              dl_calib_o,
   input  logic              dl_calib_ack_i,
   output logic              dl_swtune_o,
   output logic              clk_sel_clr_o,
   output logic              tun_req_o,
   input  logic              tun_rsp_valid_i,
   input  logic              tun_rsp_pass_i,
   output logic              dat_rst_o,
   output logic              cmd_rst_o,
   output logic              busy_o,
   output logic              done_o,
   output logic              err_o
);
   localparam int NTRIALS = CODE_LAST / CODE_STEP + 1;
   localparam int LEN_W   = $clog2(NTRIALS + 1);

   generate
      if (CODE_STEP < 1 || (CODE_LAST % CODE_STEP) != 0) begin : g_bad_step
         $error("CODE_LAST must be a multiple of a positive CODE_STEP");
      end
      if (CODE_LAST >= (1 << CODE_W)) begin : g_bad_range
         $error("CODE_LAST does not fit in CODE_W bits");
      end
      if (POLL_LIMIT < 2) begin : g_bad_poll
         $error("POLL_LIMIT must be at least 2");
      end
   endgenerate

   tune_state_e       state_q;
   logic [CODE_W-1:0] code_q;
   logic              force_q, swtune_q, final_q, err_q;
   logic              need_tune, cal_done, fail_now;
   logic              trk_clr, trk_upd;
   logic [CODE_W-1:0] best_start, final_code;
   logic [LEN_W-1:0]  best_len;

   always_comb begin
      unique case (bus_mode_e'(mode_i))
         MD_HS200, MD_SDR104: need_tune = 1'b1;
         MD_SDR50:            need_tune = sdr50_tune_cap_i;
         default:             need_tune = 1'b0;
      endcase
   end

   assign trk_clr  = (state_q == ST_IDLE) && start_i && need_tune;
   assign trk_upd  = (state_q == ST_WAIT) && tun_rsp_valid_i;
   assign fail_now = (best_len == '0) || !sclk_sel_i;

   tune_cal_poll #(.POLL_LIMIT(POLL_LIMIT)) i_cal (
      .clk      (clk),
      .rst_n    (rst_n),
      .active_i (state_q == ST_CAL),
      .ack_i    (dl_calib_ack_i),
      .finish_o (cal_done)
   );

   tune_run_track #(.CODE_W(CODE_W), .LEN_W(LEN_W)) i_track (
      .clk          (clk),
      .rst_n        (rst_n),
      .clr_i        (trk_clr),
      .upd_i        (trk_upd),
      .pass_i       (tun_rsp_pass_i),
      .code_i       (code_q),
      .best_start_o (best_start),
      .best_len_o   (best_len)
   );

   tune_place #(.CODE_W(CODE_W), .LEN_W(LEN_W), .CODE_STEP(CODE_STEP)) i_place (
      .best_start_i (best_start),
      .best_len_i   (best_len),
      .final_code_o (final_code)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         code_q   <= '0;
         force_q  <= 1'b0;
         swtune_q <= 1'b0;
         final_q  <= 1'b0;
         err_q    <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  err_q <= 1'b0;
                  if (need_tune) begin
                     code_q   <= '0;
                     force_q  <= 1'b1;
                     swtune_q <= 1'b1;
                     final_q  <= 1'b0;
                     state_q  <= ST_LOAD;
                  end else begin
                     state_q <= ST_DONE;
                  end
               end
            end
            ST_LOAD: state_q <= ST_CAL;
            ST_CAL: begin
               if (cal_done) state_q <= final_q ? ST_RDAT : ST_REQ;
            end
            ST_REQ: state_q <= ST_WAIT;
            ST_WAIT: begin
               if (tun_rsp_valid_i) begin
                  if (code_q == CODE_W'(CODE_LAST)) begin
                     state_q <= ST_EVAL;
                  end else begin
                     code_q  <= code_q + CODE_W'(CODE_STEP);
                     state_q <= ST_LOAD;
                  end
               end
            end
            ST_EVAL: begin
               if (fail_now) begin
                  err_q    <= 1'b1;
                  force_q  <= 1'b0;
                  swtune_q <= 1'b0;
                  state_q  <= ST_RDAT;
               end else begin
                  code_q  <= final_code;
                  final_q <= 1'b1;
                  state_q <= ST_LOAD;
               end
            end
            ST_RDAT: state_q <= ST_RCMD;
            ST_RCMD: state_q <= ST_DONE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign dl_code_o     = code_q;
   assign dl_force_o    = force_q;
   assign dl_swtune_o   = swtune_q;
   assign dl_calib_o    = (state_q == ST_CAL);
   assign tun_req_o     = (state_q == ST_REQ);
   assign clk_sel_clr_o = (state_q == ST_EVAL) && fail_now;
   assign dat_rst_o     = (state_q == ST_RDAT);
   assign cmd_rst_o     = (state_q == ST_RCMD);
   assign busy_o        = (state_q != ST_IDLE);
   assign done_o        = (state_q == ST_DONE);
   assign err_o         = (state_q == ST_DONE) && err_q;
endmodule

// File: rtl/phase_tune_chk.sv
module phase_tune_chk #(
   parameter int CODE_W    = 7,
   parameter int CODE_STEP = 4,
   parameter int CODE_LAST = 124
) (
   input logic              clk,
   input logic              rst_n,
   input logic [CODE_W-1:0] dl_code_o,
   input logic              dl_force_o,
   input logic              dl_calib_o,
   input logic              dl_swtune_o,
   input logic              tun_req_o,
   input logic              dat_rst_o,
   input logic              cmd_rst_o,
   input logic              busy_o,
   input logic              done_o,
   input logic              err_o
);
   a_r4_calib_needs_force: assert property (@(posedge clk) disable iff (!rst_n)
      dl_calib_o |-> dl_force_o);
   a_r4_code_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (dl_calib_o && $past(dl_calib_o)) |-> $stable(dl_code_o));
   a_r3_req_single: assert property (@(posedge clk) disable iff (!rst_n)
      tun_req_o |=> !tun_req_o);
   a_r3_req_on_grid: assert property (@(posedge clk) disable iff (!rst_n)
      tun_req_o |-> ((int'(dl_code_o) % CODE_STEP) == 0 && int'(dl_code_o) <= CODE_LAST));
   a_r6_swtune_on_req: assert property (@(posedge clk) disable iff (!rst_n)
      tun_req_o |-> dl_swtune_o);
   a_r11_dat_then_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      dat_rst_o |=> cmd_rst_o);
   a_r11_cmd_then_done: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_rst_o |=> done_o);
   a_r12_busy_held: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !done_o) |=> busy_o);
   a_r12_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !busy_o);
   a_r9_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> done_o);
endmodule

bind phase_tune_engine phase_tune_chk #(
   .CODE_W(CODE_W), .CODE_STEP(CODE_STEP), .CODE_LAST(CODE_LAST)
) i_chk (.*);

// File: tb/test_phase_tune_engine.sv
`timescale 1ns/1ps
module test_phase_tune_engine;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [1:0] mode = 2'b00;
   logic       cap = 1'b0;
   logic       sclk_sel = 1'b1;
   logic       ack = 1'b0;
   logic       rsp_valid = 1'b0;
   logic       rsp_pass = 1'b0;
   logic [6:0] code;
   logic       force_o, calib, swtune, clr, req, drst, crst, busy, done, err;

   always #2.5 clk = ~clk;

   phase_tune_engine i_phase_tune_engine (
      .clk(clk), .rst_n(rst_n), .start_i(start), .mode_i(mode),
      .sdr50_tune_cap_i(cap), .sclk_sel_i(sclk_sel),
      .dl_code_o(code), .dl_force_o(force_o), .dl_calib_o(calib),
      .dl_calib_ack_i(ack), .dl_swtune_o(swtune), .clk_sel_clr_o(clr),
      .tun_req_o(req), .tun_rsp_valid_i(rsp_valid), .tun_rsp_pass_i(rsp_pass),
      .dat_rst_o(drst), .cmd_rst_o(crst), .busy_o(busy), .done_o(done), .err_o(err)
   );

   int checks = 0;
   int errors = 0;
   bit [31:0] pattern;
   bit ack_en = 1'b1;
   int cyc = 0;
   int req_codes[$];
   int cal_codes[$];
   int cal_lens[$];
   int cal_run = 0;
   int drst_c, crst_c, done_c, start_c;
   bit done_seen, err_seen, clr_seen, sw_bad, force_bad, busy_bad, in_run;

   task automatic chk(input bit ok, input string req_tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req_tag, act, exp);
      end
   endtask

   // Per-cycle observer, sampled 1 ns after the rising edge.
   initial forever begin
      @(posedge clk); #1;
      cyc++;
      if (rst_n) begin
         if (busy !== in_run) busy_bad = 1'b1;
         if (req) begin
            req_codes.push_back(int'(code));
            if (!swtune) sw_bad = 1'b1;
         end
         if (calib) begin
            if (cal_run == 0) cal_codes.push_back(int'(code));
            cal_run++;
            if (!force_o) force_bad = 1'b1;
         end else if (cal_run > 0) begin
            cal_lens.push_back(cal_run);
            cal_run = 0;
         end
         if (clr) clr_seen = 1'b1;
         if (drst) drst_c = cyc;
         if (crst) crst_c = cyc;
         if (done) begin
            done_c = cyc;
            done_seen = 1'b1;
            err_seen = err;
            in_run = 1'b0;
         end
      end
   end

   // Calibrate acknowledge responder.
   initial forever begin
      @(negedge clk);
      ack = ack_en && calib;
   end

   // Tuning transfer responder: answers two cycles after a request.
   initial forever begin
      @(negedge clk);
      if (req) begin
         automatic int idx = int'(code) / 4;
         repeat (2) @(negedge clk);
         rsp_valid = 1'b1;
         rsp_pass  = pattern[idx];
         @(negedge clk);
         rsp_valid = 1'b0;
         rsp_pass  = 1'b0;
      end
   end

   function automatic void ref_best(input bit [31:0] p, output int bl, output int bs);
      int len = 0;
      int st = 0;
      bit prev = 0;
      bl = 0;
      bs = 0;
      for (int i = 0; i < 32; i++) begin
         if (p[i]) begin
            if (prev) len++;
            else begin
               st = 4 * i;
               len = 1;
            end
         end
         if (len > bl) begin
            bl = len;
            bs = st;
         end
         prev = p[i];
      end
   endfunction

   task automatic run(input logic [1:0] m, input bit c, input bit [31:0] p,
                      input bit sc, input bit ack_on, input bit tuned,
                      input bit extra_start, input string tag);
      int bl, bs, fin, n;
      bit exp_err;
      pattern = p;
      ack_en = ack_on;
      sclk_sel = sc;
      req_codes.delete();
      cal_codes.delete();
      cal_lens.delete();
      drst_c = -1; crst_c = -1; done_c = -1;
      done_seen = 0; clr_seen = 0; sw_bad = 0; force_bad = 0; busy_bad = 0;
      @(negedge clk);
      mode = m;
      cap = c;
      start = 1'b1;
      in_run = 1'b1;
      start_c = cyc;
      @(negedge clk);
      start = 1'b0;
      if (extra_start) begin
         repeat (50) @(negedge clk);
         mode = 2'b00;
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         mode = m;
      end
      n = 0;
      while (!done_seen && n < 60000) begin
         @(negedge clk);
         n++;
      end
      repeat (2) @(negedge clk);
      chk(done_seen, {tag, " R12 done reached"}, int'(done_seen), 1);
      chk(!busy_bad, {tag, " R12 busy window"}, int'(busy_bad), 0);
      if (!tuned) begin
         chk(done_c == start_c + 1, {tag, " R1 immediate done"}, done_c - start_c, 1);
         chk(req_codes.size() == 0 && cal_codes.size() == 0 && drst_c < 0,
             {tag, " R1 no sweep"}, req_codes.size(), 0);
         chk(!err_seen, {tag, " R1 no error"}, int'(err_seen), 0);
         return;
      end
      ref_best(p, bl, bs);
      fin = bs + 4 * ((3 * bl) >> 2);
      exp_err = (bl == 0) || !sc;
      chk(req_codes.size() == 32, {tag, " R3 trial count"}, req_codes.size(), 32);
      for (int i = 0; i < req_codes.size(); i++)
         if (req_codes[i] != 4 * i) begin
            chk(0, {tag, " R3 code order"}, req_codes[i], 4 * i);
            break;
         end
      chk(!force_bad, {tag, " R4 force with calibrate"}, int'(force_bad), 0);
      chk(!sw_bad, {tag, " R6 swtune on requests"}, int'(sw_bad), 0);
      foreach (cal_lens[i])
         if (cal_lens[i] != (ack_on ? 1 : 1000)) begin
            chk(0, {tag, " R5 calibrate length"}, cal_lens[i], ack_on ? 1 : 1000);
            break;
         end
      chk(err_seen == exp_err, {tag, " R9 R10 error flag"}, int'(err_seen), int'(exp_err));
      chk(drst_c + 1 == crst_c && crst_c + 1 == done_c, {tag, " R11 reset order"},
          crst_c - drst_c, 1);
      if (exp_err) begin
         chk(!force_o && !swtune, {tag, " R9 force and swtune cleared"},
             int'({force_o, swtune}), 0);
         chk(clr_seen, {tag, " R9 clock deselect pulse"}, int'(clr_seen), 1);
         chk(cal_codes.size() == 32, {tag, " R9 no final load"}, cal_codes.size(), 32);
      end else begin
         chk(cal_codes.size() == 33 && cal_codes[cal_codes.size()-1] == fin,
             {tag, " R7 R8 final code loaded"},
             cal_codes.size() > 0 ? cal_codes[cal_codes.size()-1] : -1, fin);
         chk(int'(code) == fin && force_o, {tag, " R8 final code held"}, int'(code), fin);
         chk(!clr_seen, {tag, " R8 no clock deselect"}, int'(clr_seen), 0);
      end
   endtask

   initial begin
      #(200000 * 5);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(!busy && !done && !req && !force_o && !swtune && !calib,
          "R12 reset state", int'({busy, done, req, force_o, swtune, calib}), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      run(2'b00, 1'b0, 32'hFFFF_FFFF, 1, 1, 0, 0, "low-speed");
      run(2'b01, 1'b0, 32'hFFFF_FFFF, 1, 1, 0, 0, "sdr50 no cap");
      run(2'b01, 1'b1, 32'hFFFF_FFFF, 1, 1, 1, 1, "R2 sdr50 cap all pass");
      run(2'b11, 1'b0, 32'h001F_FC78, 1, 1, 1, 0, "R7 hs200 two runs");
      run(2'b10, 1'b0, 32'h00F0_003C, 1, 1, 1, 0, "R7 sdr104 equal runs");
      run(2'b11, 1'b0, 32'h0000_0001, 1, 1, 1, 0, "R7 first trial only");
      run(2'b10, 1'b0, 32'h0000_0000, 1, 1, 1, 0, "R9 no pass");
      run(2'b11, 1'b0, 32'h0F0F_0F0F, 0, 1, 1, 0, "R10 clock not selected");
      run(2'b11, 1'b0, 32'h8000_0000, 1, 0, 1, 0, "R5 calibrate timeout");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule